// File: doc/BRIEF.md
# Register File Arithmetic Core

This block is the execution loop at the centre of a small processor datapath. A 32-word by 32-bit register file feeds two operands, chosen by independent left and right read addresses, into an eight-function arithmetic and logic unit. The unit's result can be written back into the register file at a destination address on the rising clock edge. Instruction fetch and decode sit outside; an external sequencer drives the function code, addresses and enables on every cycle.

The left operand may be taken from a 32-bit external data input instead of the register file. This is how constants and fresh data enter the loop, usually through the pass-left function. Both read ports drive outputs of the block, as does the carry or borrow out. With write-back disabled, a cycle has no effect on stored state and only presents register contents and the carry to the outside.

Top module: `regalu_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register to zero; after it, both read ports show 0 for any address.
- R2: Function code 000 adds: {carryOut, result} = leftOperand + rightOperand + carryIn, with carryOut being the carry out of bit 31.
- R3: Function code 001 subtracts: result = leftOperand - rightOperand - carryIn (carryIn is a borrow in), and carryOut is 1 exactly when the true difference is negative (borrow out).
- R4: Function codes 010, 011 and 100 give the bitwise AND, OR and XOR of the two operands, with carryOut 0.
- R5: Function code 101 passes the left operand and 110 passes the right operand to the result unchanged, with carryOut 0.
- R6: Function code 111 shifts the left operand left by one bit and fills bit 0 with 0; carryOut is the former bit 31 of the left operand.
- R7: With `useInput` high the left operand is `dataIn`; with it low the left operand is the register at `leftAddr`. `leftOut` always shows the register at `leftAddr`, whatever `useInput` is.
- R8: The result is stored at `destAddr` only at a rising edge where `wrEn` is 1; with `wrEn` at 0 no register changes and the cycle only drives `leftOut`, `rightOut` and `carryOut`.
- R9: Reads are combinational; a register written at an edge shows its old value on a read port in the cycle that writes it and its new value from the next cycle on.
- R10: `leftOut` and `rightOut` present the registers at `leftAddr` and `rightAddr` independently, including when both addresses are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, clears the register file |
| func | input | 3 | Function code of the arithmetic and logic unit |
| carryIn | input | 1 | Carry in for add, borrow in for subtract |
| useInput | input | 1 | Select `dataIn` as the left operand |
| dataIn | input | 32 | External data word |
| leftAddr | input | 5 | Left read address |
| rightAddr | input | 5 | Right read address |
| destAddr | input | 5 | Write-back address |
| wrEn | input | 1 | Write-back enable |
| leftOut | output | 32 | Register at the left address |
| rightOut | output | 32 | Register at the right address |
| carryOut | output | 1 | Carry out of add, borrow out of subtract, shifted-out bit of shift |

## Verification
The result of a function never reaches a port directly, so the hardest point is to prove what was written. The stimulus writes each result back and reads it on a later cycle through a read port, and in the writing cycle it points a read port at the destination to show that the old value is still there. Borrow and carry corners come from words loaded through the external input, such as a small minus a larger value and an all-ones addend with carry in.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'b000,
    OP_SUB   = 3'b001,
    OP_AND   = 3'b010,
    OP_OR    = 3'b011,
    OP_XOR   = 3'b100,
    OP_PASSL = 3'b101,
    OP_PASSR = 3'b110,
    OP_SHL   = 3'b111
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   writeBack;
    logic   leftFromInput;
    logic   carryUsed;
    aluOp_e op;
  } ctrlStrobes_t;

endpackage

// File: rtl/regalu_ctrl.sv
module regalu_ctrl
  import regalu_pkg::*;
(
  input  logic [2:0]   func,
  input  logic         carryIn,
  input  logic         useInput,
  input  logic         wrEn,
  output ctrlStrobes_t strobes,
  output logic         effCarryIn
);

  always_comb begin
    strobes.op            = aluOp_e'(func);
    strobes.writeBack     = wrEn;
    strobes.leftFromInput = useInput;
    strobes.carryUsed     = (strobes.op == OP_ADD) || (strobes.op == OP_SUB);
    effCarryIn            = strobes.carryUsed & carryIn;
  end

endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
  import regalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluOp_e            op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              cin,
  output logic [DATA_W-1:0] result,
  output logic              cout
);

  localparam int WideW = DATA_W + 1;

  logic [WideW-1:0] wideA, wideB, wideC, sumWide, diffWide;

  always_comb begin
    wideA    = {1'b0, opA};
    wideB    = {1'b0, opB};
    wideC    = {{DATA_W{1'b0}}, cin};
    sumWide  = wideA + wideB + wideC;
    diffWide = wideA - wideB - wideC;
  end

  always_comb begin
    result = '0;
    cout   = 1'b0;
    unique case (op)
      OP_ADD: begin
        result = sumWide[DATA_W-1:0];
        cout   = sumWide[DATA_W];
      end
      OP_SUB: begin
        result = diffWide[DATA_W-1:0];
        cout   = diffWide[DATA_W];
      end
      OP_AND:   result = opA & opB;
      OP_OR:    result = opA | opB;
      OP_XOR:   result = opA ^ opB;
      OP_PASSL: result = opA;
      OP_PASSR: result = opB;
      OP_SHL: begin
        result = {opA[DATA_W-2:0], 1'b0};
        cout   = opA[DATA_W-1];
      end
      default: begin
        result = '0;
        cout   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/regalu_regfile.sv
module regalu_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddrL,
  input  logic [ADDR_W-1:0] raddrR,
  output logic [DATA_W-1:0] rdataL,
  output logic [DATA_W-1:0] rdataR
);

  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] words [Depth];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < Depth; i++) words[i] <= '0;
    end else if (we) begin
      words[waddr] <= wdata;
    end
  end

  assign rdataL = words[raddrL];
  assign rdataR = words[raddrR];

endmodule

// File: rtl/regalu_datapath.sv
module regalu_datapath
  import regalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic              effCarryIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [ADDR_W-1:0] destAddr,
  output logic [DATA_W-1:0] leftOut,
  output logic [DATA_W-1:0] rightOut,
  output logic              carryOut,
  output logic [DATA_W-1:0] aluResult,
  output logic [DATA_W-1:0] leftOp
);

  logic [DATA_W-1:0] readL, readR;

  regalu_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (strobes.writeBack),
    .waddr  (destAddr),
    .wdata  (aluResult),
    .raddrL (leftAddr),
    .raddrR (rightAddr),
    .rdataL (readL),
    .rdataR (readR)
  );

  assign leftOp = strobes.leftFromInput ? dataIn : readL;

  regalu_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (strobes.op),
    .opA    (leftOp),
    .opB    (readR),
    .cin    (effCarryIn),
    .result (aluResult),
    .cout   (carryOut)
  );

  assign leftOut  = readL;
  assign rightOut = readR;

endmodule

// File: rtl/regalu_core.sv
module regalu_core
  import regalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        func,
  input  logic              carryIn,
  input  logic              useInput,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [ADDR_W-1:0] destAddr,
  input  logic              wrEn,
  output logic [DATA_W-1:0] leftOut,
  output logic [DATA_W-1:0] rightOut,
  output logic              carryOut
);

  ctrlStrobes_t      strobes;
  logic              effCarryIn;
  logic [DATA_W-1:0] aluResult;
  logic [DATA_W-1:0] leftOp;

  regalu_ctrl u_ctrl (
    .func       (func),
    .carryIn    (carryIn),
    .useInput   (useInput),
    .wrEn       (wrEn),
    .strobes    (strobes),
    .effCarryIn (effCarryIn)
  );

  regalu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .effCarryIn (effCarryIn),
    .dataIn     (dataIn),
    .leftAddr   (leftAddr),
    .rightAddr  (rightAddr),
    .destAddr   (destAddr),
    .leftOut    (leftOut),
    .rightOut   (rightOut),
    .carryOut   (carryOut),
    .aluResult  (aluResult),
    .leftOp     (leftOp)
  );

endmodule

// File: rtl/regalu_checker.sv
module regalu_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        func,
  input logic              useInput,
  input logic [DATA_W-1:0] dataIn,
  input logic [ADDR_W-1:0] leftAddr,
  input logic [ADDR_W-1:0] destAddr,
  input logic              wrEn,
  input logic [DATA_W-1:0] leftOut,
  input logic [DATA_W-1:0] rightOut,
  input logic              carryOut,
  input logic [DATA_W-1:0] aluResult,
  input logic [DATA_W-1:0] leftOp
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (leftOut == '0 && rightOut == '0)); // R1

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wrEn ##1 $stable(leftAddr) |-> $stable(leftOut)); // R8

  AST_WRITE_VISIBLE_NEXT: assert property (@(posedge clk) disable iff (rst)
    wrEn ##1 (leftAddr == $past(destAddr)) |-> leftOut == $past(aluResult)); // R9

  AST_LOGIC_CARRY_LOW: assert property (@(posedge clk) disable iff (rst)
    (func >= 3'b010 && func <= 3'b110) |-> !carryOut); // R4

  AST_SHIFT_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
    (func == 3'b111) |-> carryOut == leftOp[DATA_W-1]); // R6

  AST_INPUT_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (useInput && func == 3'b101) |-> aluResult == dataIn); // R7

endmodule

bind regalu_core regalu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .func      (func),
  .useInput  (useInput),
  .dataIn    (dataIn),
  .leftAddr  (leftAddr),
  .destAddr  (destAddr),
  .wrEn      (wrEn),
  .leftOut   (leftOut),
  .rightOut  (rightOut),
  .carryOut  (carryOut),
  .aluResult (aluResult),
  .leftOp    (leftOp)
);

// File: tb/sim_regalu_core.sv
`timescale 1ns/100ps
module sim_regalu_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  func = 3'b0;
  logic        carryIn = 1'b0;
  logic        useInput = 1'b0;
  logic [31:0] dataIn = '0;
  logic [4:0]  leftAddr = '0, rightAddr = '0, destAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] leftOut, rightOut;
  logic        carryOut;

  always #2 clk = ~clk;

  regalu_core u0 (
    .clk(clk), .rst(rst), .func(func), .carryIn(carryIn), .useInput(useInput),
    .dataIn(dataIn), .leftAddr(leftAddr), .rightAddr(rightAddr),
    .destAddr(destAddr), .wrEn(wrEn), .leftOut(leftOut), .rightOut(rightOut),
    .carryOut(carryOut)
  );

  typedef struct {
    string       tag;
    logic [31:0] expL;
    logic [31:0] expR;
    logic        expC;
  } expItem_t;

  expItem_t    scoreQ[$];
  logic [31:0] model [32];
  int          testCount = 0;
  int          failCount = 0;
  bit          done = 1'b0;

  function automatic logic [32:0] refAlu(input logic [2:0] f, input logic [31:0] a,
                                         input logic [31:0] b, input logic ci);
    logic [32:0] r;
    case (f)
      3'd0: r = {1'b0, a} + {1'b0, b} + {32'd0, ci};
      3'd1: begin
        r[31:0] = a - b - {31'd0, ci};
        r[32]   = ({1'b0, a} < ({1'b0, b} + {32'd0, ci}));
      end
      3'd2: r = {1'b0, a & b};
      3'd3: r = {1'b0, a | b};
      3'd4: r = {1'b0, a ^ b};
      3'd5: r = {1'b0, a};
      3'd6: r = {1'b0, b};
      default: r = {a[31], a[30:0], 1'b0};
    endcase
    return r;
  endfunction

  task automatic doOp(input string tag, input logic [2:0] f, input logic ci,
                      input logic ui, input logic [31:0] din, input logic [4:0] la,
                      input logic [4:0] ra, input logic [4:0] da, input logic we);
    logic [31:0] a;
    logic [32:0] r;
    expItem_t    it;
    @(negedge clk);
    func = f; carryIn = ci; useInput = ui; dataIn = din;
    leftAddr = la; rightAddr = ra; destAddr = da; wrEn = we;
    a = ui ? din : model[la];
    r = refAlu(f, a, model[ra], ci);
    it.tag = tag; it.expL = model[la]; it.expR = model[ra]; it.expC = r[32];
    scoreQ.push_back(it);
    @(posedge clk);
    if (we) model[da] = r[31:0];
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 32; i++) model[i] = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: pops expectations and compares outputs mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        testCount++;
        if (leftOut !== it.expL || rightOut !== it.expR || carryOut !== it.expC) begin
          failCount++;
          $display("FAIL %s: left=%h right=%h carry=%b expected left=%h right=%h carry=%b",
                   it.tag, leftOut, rightOut, carryOut, it.expL, it.expR, it.expC);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'hDEAD_0000 | i;
    doReset();
    doOp("R1 reset state", 3'd6, 0, 0, 0, 5'd0, 5'd31, 5'd0, 0);
    doOp("R1 reset state", 3'd6, 0, 0, 0, 5'd17, 5'd9, 5'd0, 0);
    // load two numbers through the external input
    doOp("R7 load 17", 3'd5, 0, 1, 32'd17, 5'd1, 5'd2, 5'd1, 1);
    doOp("R7 load 4", 3'd5, 0, 1, 32'd4, 5'd1, 5'd2, 5'd2, 1);
    doOp("R10 read pair", 3'd6, 0, 0, 0, 5'd1, 5'd2, 5'd0, 0);
    doOp("R10 same address", 3'd6, 0, 0, 0, 5'd1, 5'd1, 5'd0, 0);
    doOp("R3 subtract", 3'd1, 0, 0, 0, 5'd1, 5'd2, 5'd3, 1);
    doOp("R6 shift", 3'd7, 0, 0, 0, 5'd3, 5'd3, 5'd3, 1);
    doOp("R6 shift", 3'd7, 0, 0, 0, 5'd3, 5'd3, 5'd3, 1);
    doOp("R2 add input", 3'd0, 0, 1, 32'd44, 5'd3, 5'd3, 5'd3, 1);
    doOp("R2 result 96", 3'd6, 0, 0, 0, 5'd3, 5'd3, 5'd0, 0);
    // borrow and carry corners
    doOp("R3 borrow out", 3'd1, 0, 0, 0, 5'd2, 5'd1, 5'd4, 1);
    doOp("R3 borrow in", 3'd1, 1, 0, 0, 5'd1, 5'd1, 5'd5, 1);
    doOp("R3 borrow in zero", 3'd1, 1, 1, 32'd1, 5'd5, 5'd0, 5'd6, 1);
    doOp("R2 carry chain", 3'd0, 1, 1, 32'hFFFF_FFFF, 5'd4, 5'd0, 5'd7, 1);
    doOp("R2 carry wrap", 3'd0, 1, 1, 32'hFFFF_FFFE, 5'd7, 5'd2, 5'd8, 1);
    // logic and pass functions
    doOp("R7 load pattern", 3'd5, 0, 1, 32'hF0F0_A5A5, 5'd0, 5'd0, 5'd9, 1);
    doOp("R7 load pattern", 3'd5, 0, 1, 32'h0FF0_5A0F, 5'd0, 5'd0, 5'd10, 1);
    doOp("R4 and", 3'd2, 1, 0, 0, 5'd9, 5'd10, 5'd11, 1);
    doOp("R4 or", 3'd3, 1, 0, 0, 5'd9, 5'd10, 5'd12, 1);
    doOp("R4 xor", 3'd4, 1, 0, 0, 5'd9, 5'd10, 5'd13, 1);
    doOp("R4 results", 3'd6, 0, 0, 0, 5'd11, 5'd12, 5'd0, 0);
    doOp("R4 results", 3'd6, 0, 0, 0, 5'd13, 5'd13, 5'd0, 0);
    doOp("R5 pass right", 3'd6, 1, 0, 0, 5'd9, 5'd10, 5'd14, 1);
    doOp("R5 pass left", 3'd5, 1, 0, 0, 5'd9, 5'd10, 5'd15, 1);
    doOp("R5 results", 3'd6, 0, 0, 0, 5'd14, 5'd15, 5'd0, 0);
    doOp("R6 shift msb", 3'd7, 0, 1, 32'h8000_0001, 5'd9, 5'd0, 5'd16, 1);
    doOp("R6 result", 3'd6, 0, 0, 0, 5'd16, 5'd16, 5'd0, 0);
    doOp("R7 input vs leftOut", 3'd7, 0, 1, 32'h0000_0001, 5'd9, 5'd9, 5'd17, 1);
    doOp("R7 result", 3'd6, 0, 0, 0, 5'd17, 5'd9, 5'd0, 0);
    // no write-back
    doOp("R8 no write", 3'd0, 0, 1, 32'h1234_5678, 5'd1, 5'd2, 5'd1, 0);
    doOp("R8 unchanged", 3'd6, 0, 0, 0, 5'd1, 5'd2, 5'd0, 0);
    // write seen only after the edge
    doOp("R9 old value", 3'd5, 0, 1, 32'hCAFE_F00D, 5'd20, 5'd20, 5'd20, 1);
    doOp("R9 new value", 3'd5, 0, 1, 32'h0BAD_BEEF, 5'd20, 5'd20, 5'd20, 1);
    doOp("R9 new value", 3'd6, 0, 0, 0, 5'd20, 5'd20, 5'd0, 0);
    // reset mid-run
    doReset();
    doOp("R1 cleared", 3'd6, 0, 0, 0, 5'd20, 5'd3, 5'd0, 0);
    doOp("R1 cleared", 3'd6, 0, 0, 0, 5'd9, 5'd16, 5'd0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule